// File: doc/BRIEF.md
# SMBus Control Register Slave

This block is a bus slave for a two-wire SMBus link. It holds the control bytes of a differential clock fan-out buffer: an output-divider mode bit, a fan-out or PLL select, a bandwidth select, two "float or drive when halted" bits, per-output enables, per-output halt-participation bits, one spare read/write byte and a read-only identification byte. The bytes leave the block on a flat bus that feeds the output controller.

The slave answers only to the 7-bit address 1101110. A transfer begins with START, the address and a direction bit (0 write, 1 read). A write carries a command byte that loads the register pointer, then a byte count, then data bytes. Each data byte lands at the pointer, and the pointer then steps by one. A read, normally issued after a repeated START that follows a command byte, first returns the register count (5) and then register contents from the pointer onward. The master ends a read with NACK and STOP. While the power-down input is high the slave ignores the bus.

The control flow is one state machine. Its states are ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK, ST_COUNT, ST_COUNT_ACK, ST_WDATA, ST_WDATA_ACK, ST_TX and ST_TX_ACK. The transitions are these. Power-down or STOP goes to ST_IDLE from any state, and START goes to ST_ADDR from any state. After 8 bits, ST_ADDR goes to ST_ADDR_ACK on an address match and to ST_IDLE otherwise. Each receive state goes to its ACK state once 8 bits are in. On the falling SCL edge of the ninth clock, ST_ADDR_ACK goes to ST_TX for a read or to ST_CMD for a write, ST_CMD_ACK goes to ST_COUNT, ST_COUNT_ACK goes to ST_WDATA, and ST_WDATA_ACK goes back to ST_WDATA. ST_TX goes to ST_TX_ACK after 8 bits. On its falling edge ST_TX_ACK goes to ST_TX if the master acknowledged and to ST_IDLE if it did not.

Top module: `smbus_ctl_regs`

## Requirements
- R1: After reset the control bus reads byte0=0x07, byte1=0x66, byte2=0x00, byte3=0x00 (byte i on bits 8i+7..8i), and SDA is released.
- R2: The slave pulls SDA low in the ACK slot only for address 1101110. It leaves SDA released for any other address and ignores the rest of that transfer, so the registers are unchanged.
- R3: In a write, the slave ACKs the address, the command byte, the count byte and every data byte. Data byte k is stored at index command+k.
- R4: Bits that are not implemented read 0 and ignore writes: bits 3..5 of byte0, and bits 0, 3, 4 and 7 of bytes 1 and 2. All 8 bits of byte3 are writable. Byte4 is read-only and reads 0xA6 (bit 0 is 0).
- R5: Data bytes aimed at an index above 4 are acknowledged and discarded.
- R6: After address plus read bit, the slave sends 0x05 and then register bytes from the pointer onward. Indices above 4 read 0x00. A NACK from the master ends the sending and releases SDA.
- R7: The pointer is loaded by the command byte. It steps by one for every data byte written or read, and it keeps its value between transfers.
- R8: While power-down is high the slave never drives SDA, and the registers do not change. The first START after power-down falls is served normally.
- R9: A START at any point, including mid-byte, restarts address decoding. A STOP returns the slave to idle.
- R10: The slave changes SDA only while SCL is low, so a transmitted bit holds steady for the whole SCL-high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn | input | 1 | Power-down; high makes the slave ignore the bus |
| scl_in | input | 1 | Bus clock as seen on the wire |
| sda_in | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | High pulls the open-drain SDA line low |
| ctrl_bytes | output | 32 | Control bytes 0..3, byte i on bits 8i+7..8i |

## Verification
The assertions rely on the bus being slow next to clk. Every SCL level and every SDA change must last several clk cycles, so that the two-flop filter sees each START, STOP and clock edge as a separate event. They also rely on SDA changing only while SCL is low, except when the master means to signal START or STOP. The bench model holds each bus phase for five clk cycles and moves SDA only a quarter period after SCL falls. Its random transfers vary the pointer, the byte count and the data, but never the bus timing.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;
    localparam int BYTE_W   = 8;
    localparam int NUM_CTRL = 4;
    localparam int NUM_REGS = NUM_CTRL + 1;
    localparam int CNT_W    = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK
    } smb_state_e;

    // power-up value of each writable byte
    function automatic logic [BYTE_W-1:0] reg_reset(input int idx);
        case (idx)
            0:       return 8'h07;
            1:       return 8'h66;
            default: return 8'h00;
        endcase
    endfunction

    // implemented bits of each writable byte
    function automatic logic [BYTE_W-1:0] reg_wmask(input int idx);
        case (idx)
            0:       return 8'hC7;
            1, 2:    return 8'h66;
            3:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/smb_pin_filter.sv
module smb_pin_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_h,
    output logic sda_h,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [1:0] scl_sync;
    logic [1:0] sda_sync;
    logic       scl_d;
    logic       sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_in};
            sda_sync <= {sda_sync[0], sda_in};
            scl_d    <= scl_sync[1];
            sda_d    <= sda_sync[1];
        end
    end

    assign scl_h     = scl_sync[1];
    assign sda_h     = sda_sync[1];
    assign scl_rise  = scl_h & ~scl_d;
    assign scl_fall  = ~scl_h & scl_d;
    assign start_det = scl_h & scl_d & sda_d & ~sda_h;
    assign stop_det  = scl_h & scl_d & ~sda_d & sda_h;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
    import smbreg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ID_BYTE = 8'hA6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [BYTE_W-1:0]          wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [BYTE_W-1:0]          rd_idx,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_CTRL*BYTE_W-1:0] ctrl_q
);
    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_byte
        localparam logic [BYTE_W-1:0] RST_V = reg_reset(g);
        localparam logic [BYTE_W-1:0] MSK_V = reg_wmask(g);
        logic [BYTE_W-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= RST_V;
            else if (wr_en && wr_idx == BYTE_W'(g))
                q <= wr_data & MSK_V;
        end

        assign ctrl_q[g*BYTE_W +: BYTE_W] = q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CTRL; i++)
            if (rd_idx == BYTE_W'(i))
                rd_data = ctrl_q[i*BYTE_W +: BYTE_W];
        if (rd_idx == BYTE_W'(NUM_CTRL))
            rd_data = ID_BYTE;
    end

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q)); // R3
endmodule

// File: rtl/smbus_ctl_regs.sv
module smbus_ctl_regs
    import smbreg_pkg::*;
#(
    parameter logic [6:0]        DEV_ADDR = 7'b1101110,
    parameter logic [BYTE_W-1:0] ID_BYTE  = 8'hA6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pwrdn,
    input  logic                       scl_in,
    input  logic                       sda_in,
    output logic                       sda_oe,
    output logic [NUM_CTRL*BYTE_W-1:0] ctrl_bytes
);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0]  FULL_BYTE = CNT_W'(BYTE_W);
    localparam logic [BYTE_W-1:0] REG_COUNT = BYTE_W'(NUM_REGS);

    smb_state_e        state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] ptr;
    logic              rw_rd;
    logic              m_ack;
    logic              scl_h, sda_h, scl_rise, scl_fall, start_det, stop_det;
    logic              byte_done;
    logic              wr_en;
    logic [BYTE_W-1:0] rd_data;

    smb_pin_filter u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_h     (scl_h),
        .sda_h     (sda_h),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_regbank #(.ID_BYTE(ID_BYTE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ptr),
        .wr_data (shreg),
        .rd_idx  (ptr),
        .rd_data (rd_data),
        .ctrl_q  (ctrl_bytes)
    );

    assign byte_done = scl_fall && (bit_cnt == FULL_BYTE);

    // next-state logic
    always_comb begin
        state_nx = state;
        if (pwrdn || stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_done)
                                  state_nx = (shreg[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) state_nx = rw_rd ? ST_TX : ST_CMD;
                ST_CMD:       if (byte_done) state_nx = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) state_nx = ST_COUNT;
                ST_COUNT:     if (byte_done) state_nx = ST_COUNT_ACK;
                ST_COUNT_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_TX:        if (scl_fall && bit_cnt == LAST_BIT) state_nx = ST_TX_ACK;
                ST_TX_ACK:    if (scl_fall) state_nx = m_ack ? ST_TX : ST_IDLE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // shift register, bit counter and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
            rw_rd   <= 1'b0;
            m_ack   <= 1'b0;
        end else if (pwrdn || stop_det || start_det) begin
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_CMD, ST_COUNT, ST_WDATA: begin
                    if (scl_rise && bit_cnt < FULL_BYTE) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_h};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (byte_done) begin
                        bit_cnt <= '0;
                        if (state == ST_ADDR)  rw_rd <= shreg[0];
                        if (state == ST_CMD)   ptr   <= shreg;
                        if (state == ST_WDATA) ptr   <= ptr + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && rw_rd) begin
                        shreg   <= REG_COUNT;
                        bit_cnt <= '0;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == LAST_BIT) begin
                            bit_cnt <= '0;
                        end else begin
                            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) m_ack <= ~sda_h;
                    if (scl_fall && m_ack) begin
                        shreg <= rd_data;
                        ptr   <= ptr + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        wr_en  = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_COUNT_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_TX:    sda_oe = ~shreg[BYTE_W-1];
            ST_WDATA: wr_en  = byte_done && !pwrdn;
            default: ;
        endcase
    end

    AST_PWRDN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn |=> !sda_oe); // R8
    AST_PWRDN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn |=> $stable(ctrl_bytes)); // R8
    AST_ACK_ONLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && $past(state) == ST_ADDR) |-> ($past(shreg[7:1]) == DEV_ADDR)); // R2
    AST_START_REDECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !pwrdn) |=> (state == ST_ADDR && bit_cnt == '0)); // R9
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state == ST_IDLE); // R9
    AST_TX_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && $past(state) == ST_TX && scl_h && $past(scl_h)) |-> $stable(sda_oe)); // R10
    AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= FULL_BYTE); // R3
endmodule

// File: tb/smbus_ctl_regs_test.sv
module smbus_ctl_regs_test;
    localparam int         CLK_T = 10;
    localparam int         Q     = 5;
    localparam logic [6:0] ADR   = 7'b1101110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwrdn = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [31:0] ctrl_bytes;
    logic        line_sda;

    int          n_chk = 0;
    int          n_fail = 0;
    logic        done = 1'b0;
    logic [7:0]  mdl [0:3];
    logic [7:0]  wbuf [0:7];
    int          mptr = 0;

    assign line_sda = sda_m & ~sda_oe;

    always #(CLK_T/2) clk = ~clk;

    smbus_ctl_regs uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwrdn      (pwrdn),
        .scl_in     (scl_m),
        .sda_in     (line_sda),
        .sda_oe     (sda_oe),
        .ctrl_bytes (ctrl_bytes)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bmask(input int i);
        if (i == 0) return 8'hC7;
        if (i == 1 || i == 2) return 8'h66;
        if (i == 3) return 8'hFF;
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_rd(input int p);
        if (p < 4) return mdl[p];
        if (p == 4) return 8'hA6;
        return 8'h00;
    endfunction

    task automatic start_c();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = !line_sda; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rd_byte(input logic nack, output logic [7:0] d, output logic stable_ok);
        logic a;
        sda_m = 1'b1;
        stable_ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            a = line_sda; tick(Q);
            if (line_sda !== a) stable_ok = 1'b0;
            d[i] = a;
            scl_m = 1'b0;
        end
        sda_m = nack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic chk_regs(input string req);
        chk(req, ctrl_bytes, {mdl[3], mdl[2], mdl[1], mdl[0]});
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] idx, input int n,
                            input logic exp_ack, input string req);
        logic ack;
        start_c();
        wr_byte({a, 1'b0}, ack); chk(req, 32'(ack), 32'(exp_ack));
        wr_byte(idx, ack);       chk(req, 32'(ack), 32'(exp_ack));
        wr_byte(8'(n), ack);     chk(req, 32'(ack), 32'(exp_ack));
        for (int k = 0; k < n; k++) begin
            wr_byte(wbuf[k], ack); chk(req, 32'(ack), 32'(exp_ack));
        end
        stop_c();
        if (exp_ack) begin
            mptr = int'(idx);
            for (int k = 0; k < n; k++) begin
                if (mptr < 4) mdl[mptr] = wbuf[k] & bmask(mptr);
                mptr++;
            end
        end
        tick(2);
        chk_regs(req);
    endtask

    task automatic do_read(input logic [7:0] idx, input logic set_idx, input int n,
                           input string req);
        logic       ack;
        logic       stb;
        logic [7:0] d;
        if (set_idx) begin
            start_c();
            wr_byte({ADR, 1'b0}, ack); chk(req, 32'(ack), 32'd1);
            wr_byte(idx, ack);         chk(req, 32'(ack), 32'd1);
            mptr = int'(idx);
        end
        start_c();
        wr_byte({ADR, 1'b1}, ack); chk(req, 32'(ack), 32'd1);
        rd_byte(1'b0, d, stb);
        chk(req, 32'(d), 32'h05);
        chk("R10", 32'(stb), 32'd1);
        for (int k = 0; k < n; k++) begin
            rd_byte(k == n - 1, d, stb);
            chk(req, 32'(d), 32'(exp_rd(mptr)));
            chk("R10", 32'(stb), 32'd1);
            mptr++;
        end
        stop_c();
        tick(2);
        chk("R6", 32'(sda_oe), 32'd0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic ack;
        int   idx;
        int   n;
        void'($urandom(32'd1234));
        mdl[0] = 8'h07; mdl[1] = 8'h66; mdl[2] = 8'h00; mdl[3] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R1 reset values
        chk("R1", ctrl_bytes, 32'h0000_6607);
        chk("R1", 32'(sda_oe), 32'd0);

        // R6 full read from index 0, includes ID byte (R4) and index 5
        do_read(8'd0, 1'b1, 6, "R6");

        // R4 masks: all ones into every byte
        for (int k = 0; k < 5; k++) wbuf[k] = 8'hFF;
        do_write(ADR, 8'd0, 5, 1'b1, "R4");
        chk("R4", ctrl_bytes, 32'hFF66_66C7);
        do_read(8'd4, 1'b1, 1, "R4");

        // R5 writes past index 4 acknowledged and dropped
        wbuf[0] = 8'h3C; wbuf[1] = 8'h11; wbuf[2] = 8'h22; wbuf[3] = 8'h33;
        do_write(ADR, 8'd3, 4, 1'b1, "R5");
        chk("R5", ctrl_bytes[31:24], 32'h3C);

        // R7 pointer carries over into a read with no command byte
        wbuf[0] = 8'h00; wbuf[1] = 8'h24;
        do_write(ADR, 8'd1, 2, 1'b1, "R7");
        do_read(8'd0, 1'b0, 2, "R7");
        do_read(8'd0, 1'b0, 1, "R6");

        // R2 other addresses ignored
        wbuf[0] = 8'h00; wbuf[1] = 8'h00;
        do_write(7'b1101111, 8'd0, 2, 1'b0, "R2");
        do_write(7'b0101110, 8'd2, 2, 1'b0, "R2");

        // R8 power-down
        pwrdn = 1'b1; tick(4);
        wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'h00;
        do_write(ADR, 8'd0, 3, 1'b0, "R8");
        chk("R8", 32'(sda_oe), 32'd0);
        pwrdn = 1'b0; tick(4);
        wbuf[0] = 8'h01; wbuf[1] = 8'h42;
        do_write(ADR, 8'd0, 2, 1'b1, "R8");

        // R9 repeated START mid-byte restarts decoding
        start_c();
        wr_byte({ADR, 1'b0}, ack); chk("R9", 32'(ack), 32'd1);
        for (int i = 0; i < 3; i++) begin
            sda_m = i[0]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        wbuf[0] = 8'h5A;
        do_write(ADR, 8'd3, 1, 1'b1, "R9");

        // R3 / R6 constrained random mix
        for (int it = 0; it < 24; it++) begin
            idx = int'($urandom_range(0, 6));
            n   = int'($urandom_range(1, 4));
            if ($urandom_range(0, 1) == 1) begin
                for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
                do_write(ADR, 8'(idx), n, 1'b1, "R3");
            end else begin
                do_read(8'(idx), 1'b1, n, "R6");
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule